// File: doc/BRIEF.md
# Prescaled Reference-Compare Timer

This block is a 16-bit general-purpose timer driven through a small register window. Software programs a mode word that holds the enable bit, the clock-source choice, an 8-bit prescale value, the restart-on-match choice and the interrupt enable. It also loads a reference value and, when it needs to, a starting count. The prescaler divides the system clock by the prescale value plus one, with an extra divide-by-16 stage when the slow source is chosen. Each terminal pulse of the prescaler advances the counter by one.

When the counter holds the reference value on a prescaler pulse, the timer latches a reference event in its event register. If restart mode is on, the counter also goes back to zero. The interrupt output is the reference event gated by the interrupt enable. Software acknowledges the event by writing a 1 to its bit. If a mode write turns the timer off after it was on, the reference register is cleared.

Top module: `prescale_ref_timer`

## Requirements
- R1: After reset the mode, reference, capture, counter and event registers all read zero and `irq` is low.
- R2: While mode bit 0 (enable) is 0, the counter keeps its value except when software writes it.
- R3: The count divisor is (mode bits 15:8) + 1 when mode bits 2:1 equal 1, and 16 times that when they equal 2. After the mode write that enables the timer, the counter reads floor(n / divisor) n cycles later, starting from zero.
- R4: When mode bits 2:1 equal 0 or 3, the counter does not advance, even with the enable bit set.
- R5: With mode bit 3 set, a pulse that finds the counter equal to the reference value returns it to 0. With bit 3 clear, the counter keeps counting upward and wraps from 0xFFFF to 0x0000.
- R6: Event bit 1 (reference flag) sets on the prescaler pulse at which the counter equals the reference value, and it stays set until it is cleared.
- R7: `irq` is high exactly when mode bit 4 and event bit 1 are both 1.
- R8: A write to the event register clears each bit written as 1 and leaves the bits written as 0 unchanged.
- R9: A mode write that takes bit 0 from 1 to 0 clears the reference register and then stores the written mode value. Mode writes that keep bit 0 at 0 or at 1 leave the reference register unchanged.
- R10: The register offsets are mode 0x00, reference 0x04, capture 0x08, counter 0x0C and event 0x11 (bits 1:0). The capture register reads back what was written. Any other offset reads as zero.
- R11: A write to the counter loads the written value and restarts the prescaler phase, so the next advance comes one full divisor later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| irq | output | 1 | Reference-event interrupt |

## Verification
On every cycle the assertions check the following: prescaler pulses occur only with a valid running source, a stopped counter holds, a match sets the reference flag, and in restart mode a match returns the counter to zero. They also check that the flag stays set until a write clears it, that a counter load takes effect, and that a match with the interrupt enabled drives the interrupt. The exact divisor arithmetic can only be shown by the bench's scenarios, which compare counter readings after measured waits with its own model. The same holds for the 16-bit wrap, the clearing of the reference register when the enable bit falls, the offset decode and the independent clearing of each event bit.

// File: rtl/ptmr_pkg.sv
`timescale 1ns/1ps
package ptmr_pkg;
  localparam logic [4:0] OFF_MODE = 5'h00;
  localparam logic [4:0] OFF_REF  = 5'h04;
  localparam logic [4:0] OFF_CAP  = 5'h08;
  localparam logic [4:0] OFF_CNT  = 5'h0C;
  localparam logic [4:0] OFF_EVT  = 5'h11;

  localparam int MB_EN      = 0;
  localparam int MB_SRC_LSB = 1;
  localparam int MB_RESTART = 3;
  localparam int MB_IE      = 4;
  localparam int MB_PSC_LSB = 8;

  typedef enum logic [1:0] {
    SRC_OFF   = 2'd0,
    SRC_SYS   = 2'd1,
    SRC_SLOW  = 2'd2,
    SRC_RSVD  = 2'd3
  } src_sel_e;

  function automatic logic src_runs(input logic [1:0] sel);
    return (sel == SRC_SYS) || (sel == SRC_SLOW);
  endfunction
endpackage

// File: rtl/ptmr_prescaler.sv
`timescale 1ns/1ps
module ptmr_prescaler #(
  parameter int PSC_W    = 8,
  parameter int EXT_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PSC_W-1:0] psc,
  input  logic             slow,
  output logic             tick
);
  localparam int PW = PSC_W + EXT_LOG2;

  function automatic logic [PW-1:0] last_phase(input logic [PSC_W-1:0] p,
                                               input logic s);
    logic [PW:0] d;
    d = {{(EXT_LOG2+1){1'b0}}, p} + 1'b1;
    if (s) d = d << EXT_LOG2;
    d = d - 1'b1;
    return d[PW-1:0];
  endfunction

  logic [PW-1:0] phase_q;
  logic [PW-1:0] phase_end;

  assign phase_end = last_phase(psc, slow);
  assign tick      = run && !restart && (phase_q == phase_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               phase_q <= '0;
    else if (!run || restart) phase_q <= '0;
    else if (tick)            phase_q <= '0;
    else                      phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/ptmr_counter.sv
`timescale 1ns/1ps
module ptmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart_en,
  input  logic [CNT_W-1:0] ref_val,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             hit
);
  function automatic logic [CNT_W-1:0] advance(input logic [CNT_W-1:0] c,
                                               input logic at_ref,
                                               input logic rs);
    if (rs && at_ref) return '0;
    return c + 1'b1;
  endfunction

  logic at_ref;
  assign at_ref = (count == ref_val);
  assign hit    = tick && at_ref;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (tick) count <= advance(count, at_ref, restart_en);
  end
endmodule

// File: rtl/prescale_ref_timer.sv
`timescale 1ns/1ps
module prescale_ref_timer #(
  parameter int ADDR_W   = 5,
  parameter int CNT_W    = 16,
  parameter int PSC_W    = 8,
  parameter int EXT_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq
);
  import ptmr_pkg::*;

  logic [CNT_W-1:0] mode_q, ref_q, cap_q, count;
  logic [1:0]       ev_q;
  logic mode_wr, ref_wr, cap_wr, cnt_load, ev_wr;
  logic run, tick, hit, ie, restart_en, ev_ref, ev_clr_ref, pre_restart;
  logic [1:0] src;

  assign mode_wr  = wr_en && (addr == OFF_MODE);
  assign ref_wr   = wr_en && (addr == OFF_REF);
  assign cap_wr   = wr_en && (addr == OFF_CAP);
  assign cnt_load = wr_en && (addr == OFF_CNT);
  assign ev_wr    = wr_en && (addr == OFF_EVT);

  assign src         = mode_q[MB_SRC_LSB +: 2];
  assign run         = mode_q[MB_EN] && src_runs(src);
  assign ie          = mode_q[MB_IE];
  assign restart_en  = mode_q[MB_RESTART];
  assign pre_restart = mode_wr || ref_wr || cnt_load;
  assign ev_ref      = ev_q[1];
  assign ev_clr_ref  = ev_wr && wdata[1];

  ptmr_prescaler #(.PSC_W(PSC_W), .EXT_LOG2(EXT_LOG2)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (pre_restart),
    .psc     (mode_q[MB_PSC_LSB +: PSC_W]),
    .slow    (src == SRC_SLOW),
    .tick    (tick)
  );

  ptmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .restart_en (restart_en),
    .ref_val    (ref_q),
    .load       (cnt_load),
    .load_val   (wdata),
    .count      (count),
    .hit        (hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ref_q  <= '0;
      cap_q  <= '0;
      ev_q   <= '0;
    end else begin
      if (mode_wr) begin
        mode_q <= wdata;
        if (mode_q[MB_EN] && !wdata[MB_EN]) ref_q <= '0;
      end
      if (ref_wr) ref_q <= wdata;
      if (cap_wr) cap_q <= wdata;
      ev_q[0] <= ev_q[0] && !(ev_wr && wdata[0]);
      ev_q[1] <= hit || (ev_q[1] && !ev_clr_ref);
    end
  end

  always_comb begin
    case (addr)
      OFF_MODE: rdata = mode_q;
      OFF_REF:  rdata = ref_q;
      OFF_CAP:  rdata = cap_q;
      OFF_CNT:  rdata = count;
      OFF_EVT:  rdata = {{(CNT_W-2){1'b0}}, ev_q};
      default:  rdata = '0;
    endcase
  end

  assign irq = ie && ev_ref;
endmodule

// File: rtl/ptmr_checker.sv
`timescale 1ns/1ps
module ptmr_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             tick,
  input logic             hit,
  input logic [CNT_W-1:0] count,
  input logic             restart_en,
  input logic             cnt_load,
  input logic [CNT_W-1:0] wdata,
  input logic             ie,
  input logic             mode_wr,
  input logic             ev_ref,
  input logic             ev_clr_ref,
  input logic             irq
);
  // R3
  tick_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run);

  // R2
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_load) |=> $stable(count));

  // R6
  ref_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> ev_ref);

  // R5
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && restart_en && !cnt_load) |=> (count == '0));

  // R7
  irq_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ie && !mode_wr) |=> irq);

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ref && !ev_clr_ref) |=> ev_ref);

  // R11
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> (count == $past(wdata)));
endmodule

bind prescale_ref_timer ptmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .tick       (tick),
  .hit        (hit),
  .count      (count),
  .restart_en (restart_en),
  .cnt_load   (cnt_load),
  .wdata      (wdata),
  .ie         (ie),
  .mode_wr    (mode_wr),
  .ev_ref     (ev_ref),
  .ev_clr_ref (ev_clr_ref),
  .irq        (irq)
);

// File: tb/tb_prescale_ref_timer.sv
`timescale 1ns/1ps
module tb_prescale_ref_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int nvec = 0;
  int nbad = 0;

  localparam logic [4:0] A_MODE = 5'h00, A_REF = 5'h04, A_CAP = 5'h08,
                         A_CNT = 5'h0C, A_EVT = 5'h11;

  prescale_ref_timer dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                          .wdata(wdata), .rdata(rdata), .irq(irq));

  always #10 clk = ~clk;

  function automatic int exp_div(input int psc, input int src);
    return (psc + 1) * ((src == 2) ? 16 : 1);
  endfunction

  function automatic int exp_count(input int n, input int dv, input int rv,
                                   input bit rs);
    int t;
    t = n / dv;
    if (rs) return t % (rv + 1);
    return t % 65536;
  endfunction

  function automatic int exp_flag(input int n, input int dv, input int rv);
    return ((n / dv) >= (rv + 1)) ? 1 : 0;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    nvec++;
    if (got != exp) begin
      nbad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output int d);
    addr = a;
    #1;
    d = int'(rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] mk_mode(input int psc, input bit ie,
                                          input bit rs, input int src,
                                          input bit en);
    return {psc[7:0], 3'b000, ie, rs, src[1:0], en};
  endfunction

  initial begin
    #(20 * 150000);
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    int v;
    void'($urandom(32'd4242));
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(A_MODE, v); check("R1 mode", v, 0);
    rd(A_REF, v);  check("R1 ref", v, 0);
    rd(A_CAP, v);  check("R1 cap", v, 0);
    rd(A_CNT, v);  check("R1 cnt", v, 0);
    rd(A_EVT, v);  check("R1 evt", v, 0);
    check("R1 irq", int'(irq), 0);

    // R10 decode and readback
    wr(A_CAP, 16'hA5A5); rd(A_CAP, v); check("R10 cap", v, 16'hA5A5);
    wr(A_MODE, 16'h1234); rd(A_MODE, v); check("R10 mode", v, 16'h1234);
    rd(5'h14, v); check("R10 unmapped 0x14", v, 0);
    rd(5'h1F, v); check("R10 unmapped 0x1F", v, 0);
    rd(5'h10, v); check("R10 unmapped 0x10", v, 0);

    // R2 disabled holds
    wr(A_MODE, mk_mode(3, 0, 0, 1, 0));
    wr(A_CNT, 16'd7); idle(50); rd(A_CNT, v); check("R2 hold", v, 7);

    // R4 unsupported sources
    wr(A_CNT, 16'd0); wr(A_MODE, mk_mode(0, 0, 0, 0, 1));
    idle(30); rd(A_CNT, v); check("R4 src0", v, 0);
    wr(A_MODE, mk_mode(0, 0, 0, 3, 1));
    idle(30); rd(A_CNT, v); check("R4 src3", v, 0);

    // R9 enable fall clears reference
    wr(A_REF, 16'h0055);
    wr(A_MODE, mk_mode(0, 0, 0, 1, 1));
    wr(A_MODE, mk_mode(0, 0, 0, 1, 1));
    rd(A_REF, v); check("R9 1->1 keeps ref", v, 16'h0055);
    wr(A_MODE, 16'h0102);
    rd(A_REF, v); check("R9 1->0 clears ref", v, 0);
    rd(A_MODE, v); check("R9 mode stored", v, 16'h0102);
    wr(A_REF, 16'h0066);
    wr(A_MODE, 16'h0002);
    rd(A_REF, v); check("R9 0->0 keeps ref", v, 16'h0066);

    // R11 load restarts prescale phase (divisor 5)
    wr(A_REF, 16'hFFF0);
    wr(A_MODE, mk_mode(4, 0, 0, 1, 1));
    idle(13);
    wr(A_CNT, 16'h0100);
    idle(7); rd(A_CNT, v); check("R11 load+advance", v, 16'h0101);

    // R5 wrap without restart
    wr(A_MODE, 16'h0000);
    wr(A_REF, 16'd5);
    wr(A_EVT, 16'h0003);
    wr(A_CNT, 16'hFFFE);
    wr(A_MODE, mk_mode(0, 0, 0, 1, 1));
    idle(3); rd(A_CNT, v); check("R5 wrap", v, 1);
    rd(A_EVT, v); check("R6 no match during wrap", v, 0);

    // R6 R7 R8 flag, interrupt and write-1-to-clear
    wr(A_MODE, 16'h0000);
    wr(A_CNT, 16'd0);
    wr(A_REF, 16'd0);
    wr(A_MODE, mk_mode(0, 1, 1, 1, 1));
    idle(4);
    wr(A_MODE, mk_mode(0, 1, 1, 1, 0));
    rd(A_EVT, v); check("R6 flag set", v, 2);
    check("R7 irq high", int'(irq), 1);
    wr(A_EVT, 16'h0001);
    rd(A_EVT, v); check("R8 zero bit kept", v, 2);
    wr(A_MODE, mk_mode(0, 0, 1, 1, 0));
    check("R7 irq masked", int'(irq), 0);
    wr(A_MODE, mk_mode(0, 1, 1, 1, 0));
    check("R7 irq unmasked", int'(irq), 1);
    wr(A_EVT, 16'h0002);
    rd(A_EVT, v); check("R8 cleared", v, 0);
    check("R7 irq after clear", int'(irq), 0);

    // R3 R5 R6 R7 random configurations
    for (int i = 0; i < 40; i++) begin
      int psc, src, rv, n, dv, got;
      bit rs, ie;
      psc = int'($urandom % 4);
      src = ($urandom % 2) ? 2 : 1;
      rv  = int'($urandom % 24);
      n   = int'($urandom % 400);
      rs  = 1'($urandom % 2);
      ie  = 1'($urandom % 2);
      dv  = exp_div(psc, src);
      wr(A_MODE, 16'h0000);
      wr(A_CNT, 16'd0);
      wr(A_EVT, 16'h0003);
      wr(A_REF, 16'(rv));
      wr(A_MODE, mk_mode(psc, ie, rs, src, 1));
      idle(n);
      rd(A_CNT, got); check("R3 R5 random count", got, exp_count(n, dv, rv, rs));
      rd(A_EVT, got); check("R6 random flag", got, 2 * exp_flag(n, dv, rv));
      check("R7 random irq", int'(irq), (ie ? 1 : 0) * exp_flag(n, dv, rv));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule